// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is the slave end of a two-wire serial bus with an open-drain data line. It watches the clock and data lines through synchronizers running on the system clock. It frames transfers on start and stop conditions and answers to one 7-bit device address. Six bits of that address are fixed. The seventh comes from a strap pin, so two instances can share one bus.

A write transfer sets a base pointer into a sixteen-entry byte array and then stores data bytes at successive locations. A later read transfer streams bytes out, starting from the pointer that the write left behind. The pointer saturates at the top entry in both directions of transfer. A base address beyond the array is refused.

Logic on the chip side sees the array through a registered read port.

Top module: `tws_reg_slave`

## Requirements
- R1: After reset, SDA is released (`sda_pull_o` = 0) and all sixteen registers (indices 0x0..0xF) read 0x00.
- R2: A start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) aborts any byte in progress, and its partial bits are never stored. A start begins address matching again, including as a repeated start with no stop before it. A stop returns the slave to idle. The slave releases SDA on the clock after either condition.
- R3: The first byte after a start is sent MSB first. Its upper seven bits are compared with binary 100110 followed by the level of `strap_i`. Bit 0 gives the direction: 1 means read and 0 means write. On a match, the slave pulls SDA low for the whole ninth SCL pulse.
- R4: On an address mismatch, the slave gives no acknowledge. It ignores every following bit until the next start, with no acknowledge and no register change.
- R5: In a write, the byte after the address is the base pointer. Each following complete data byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R6: The write pointer stops at 0x0F, so every further data byte overwrites register 0x0F.
- R7: A base pointer byte above 0x0F is not acknowledged. The rest of that transfer is ignored until the next start, and the registers and the pointer keep their values.
- R8: A read sends bytes MSB first, starting at the pointer left by earlier transfers. The pointer advances once for each byte loaded for sending, so a new read resumes just after the last byte sent.
- R9: If the master does not acknowledge a read byte, the slave releases SDA and stays released through any further SCL pulses until the next start.
- R10: The read pointer stops at 0x0F, so every further read byte repeats register 0x0F.
- R11: `loc_data_o` returns the register at `loc_addr_i` one clock after the address is presented. A received data byte is committed on the fourth clock edge after SCL falls at the pin at the end of its eighth bit. A local read of the same register on that edge returns the old value, and the new value appears one clock later.
- R12: `sda_pull_o` is asserted only while SCL is low. It is never asserted while SCL is high during a bit that the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Level for the lowest device address bit |
| loc_addr_i | input | 4 | Register index for the local read port |
| sda_pull_o | output | 1 | 1 = drive SDA low, 0 = release it |
| loc_data_o | output | 8 | Registered local read data |

## Verification
A bus write that commits a byte and a local read of that same register can land on one clock edge. The bench provokes this by presenting the target index on the local port and then dropping SCL at the end of the eighth data bit on a known clock. From that clock it counts the synchronizer and pipeline registers. It then expects the old contents exactly four edges later and the new contents on the fifth. A write-first array, or a commit one clock early or late, breaks this count.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_BASE,
    ST_BASE_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK
  } tws_state_e;

endpackage

// File: rtl/tws_sync_edge.sv
module tws_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus level is high, so every stage resets to one.
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s_o    = scl_pipe[STAGES-1];
  assign sda_s_o    = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  loc_raddr,
  output logic [DATA_W-1:0] loc_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Both read ports are registered and read-first.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      loc_rdata <= '0;
    end else begin
      bus_rdata <= mem[bus_raddr];
      loc_rdata <= mem[loc_raddr];
    end
  end

endmodule

// File: rtl/tws_protocol.sv
module tws_protocol
  import tws_pkg::*;
#(
  parameter int          DEPTH  = 16,
  parameter int          DATA_W = 8,
  parameter logic [5:0]  DEV_HI = 6'b100110,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_i,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [IDX_W-1:0]  ptr_o
);

  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(DEPTH - 1);
  localparam logic [DATA_W-1:0] TOP_BYTE = DATA_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DATA_W);

  tws_state_e        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  ptr;
  logic              is_read;
  logic              mack;
  logic              byte_done;
  logic              dev_hit;
  logic              base_ok;
  logic [IDX_W-1:0]  ptr_next;

  assign byte_done = scl_fall && (bitcnt == FULL_CNT);
  assign dev_hit   = (shreg[DATA_W-1:1] == {DEV_HI, strap_i});
  assign base_ok   = (shreg <= TOP_BYTE);
  assign ptr_next  = (ptr == TOP_IDX) ? ptr : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      ptr        <= '0;
      is_read    <= 1'b0;
      mack       <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state      <= ST_DEV;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;

          ST_DEV, ST_BASE, ST_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[DATA_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (dev_hit) begin
                  is_read    <= shreg[0];
                  sda_pull_o <= 1'b1;
                  state      <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_BASE) begin
                if (base_ok) begin
                  ptr        <= shreg[IDX_W-1:0];
                  sda_pull_o <= 1'b1;
                  state      <= ST_BASE_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_en_o    <= 1'b1;
                wr_idx_o   <= ptr;
                wr_data_o  <= shreg;
                ptr        <= ptr_next;
                sda_pull_o <= 1'b1;
                state      <= ST_WDATA_ACK;
              end
            end
          end

          ST_DEV_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                shreg      <= rd_data;
                sda_pull_o <= ~rd_data[DATA_W-1];
                ptr        <= ptr_next;
                state      <= ST_TX;
              end else begin
                sda_pull_o <= 1'b0;
                state      <= ST_BASE;
              end
            end
          end

          ST_BASE_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              bitcnt     <= '0;
              state      <= ST_WDATA;
            end
          end

          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == FULL_CNT) begin
                sda_pull_o <= 1'b0;
                bitcnt     <= '0;
                state      <= ST_TX_ACK;
              end else begin
                shreg      <= {shreg[DATA_W-2:0], 1'b0};
                sda_pull_o <= ~shreg[DATA_W-2];
              end
            end
          end

          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                shreg      <= rd_data;
                sda_pull_o <= ~rd_data[DATA_W-1];
                ptr        <= ptr_next;
                state      <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end

          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign ptr_o = ptr;

endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave #(
  parameter int         REG_COUNT   = 16,
  parameter int         DATA_W      = 8,
  parameter logic [5:0] DEV_HI      = 6'b100110,
  parameter int         SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  input  logic [IDX_W-1:0]  loc_addr_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] loc_data_o
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [IDX_W-1:0]  ptr;
  logic [DATA_W-1:0] bus_rdata;

  tws_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tws_protocol #(
    .DEPTH  (REG_COUNT),
    .DATA_W (DATA_W),
    .DEV_HI (DEV_HI)
  ) u_proto (
    .clk        (clk),
    .rst        (rst),
    .strap_i    (strap_i),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .rd_data    (bus_rdata),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .ptr_o      (ptr)
  );

  tws_regfile #(
    .DEPTH  (REG_COUNT),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_en),
    .waddr     (wr_idx),
    .wdata     (wr_data),
    .bus_raddr (ptr),
    .bus_rdata (bus_rdata),
    .loc_raddr (loc_addr_i),
    .loc_rdata (loc_data_o)
  );

endmodule

// File: rtl/tws_reg_slave_chk.sv
module tws_reg_slave_chk #(
  parameter int IDX_W = 4,
  parameter int TOP   = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_pull,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TOP);

  // R2: bus released after a start
  a_r2_start_release: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull);

  // R2: bus released after a stop
  a_r2_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);

  // R12: pull only begins in the SCL low phase
  a_r12_pull_low_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);

  // R5: commits happen in the SCL low phase
  a_r5_write_low_phase: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !scl_s);

  // R5: pointer advances by one below the top
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx != TOP_IDX)) |-> (ptr == wr_idx + 1'b1));

  // R6: pointer holds at the top
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == TOP_IDX)) |-> (ptr == TOP_IDX));

endmodule

bind tws_reg_slave tws_reg_slave_chk #(
  .IDX_W (IDX_W),
  .TOP   (REG_COUNT - 1)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_pull  (sda_pull_o),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .ptr       (ptr)
);

// File: tb/tb_tws_reg_slave.sv
`timescale 1ns/1ps
module tb_tws_reg_slave;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b1;
  logic [3:0] loc_addr = 4'd0;
  logic       pull;
  logic [7:0] loc_data;
  wire        sda_line = sda_m & ~pull;

  int checks = 0;
  int fails  = 0;
  logic mon_hi = 1'b0;
  logic [7:0] model [16];

  always #2.5 clk = ~clk;

  tws_reg_slave dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .loc_addr_i (loc_addr),
    .sda_pull_o (pull),
    .loc_data_o (loc_data)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R12: per-clock check while the master drives a bit with SCL high
  always @(negedge clk) begin
    if (mon_hi) begin
      checks++;
      if (pull) begin
        fails++;
        $display("FAIL R12 actual=%0h expected=%0h", pull, 0);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    report();
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(Q);
    scl_m = 1'b1; mon_hi = 1'b1; wt(2 * Q);
    mon_hi = 1'b0; scl_m = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_line; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    check_eq(req, !b, exp_ack);
  endtask

  task automatic recv_byte(input logic mack, input logic [7:0] exp, input string req);
    logic b;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!mack);
    check_eq(req, v, exp);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 16; i++) begin
      loc_addr = 4'(i);
      wt(1);
      check_eq(req, loc_data, model[i]);
    end
  endtask

  initial begin
    logic b;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    wt(5);
    rst = 1'b0;
    wt(2);

    // R1: reset state
    check_eq("R1", pull, 0);
    check_regs("R1");

    // R5/R3: write three bytes from base 2 (address 1001101, write -> 0x9A)
    bus_start();
    send_byte(8'h9A, 1'b1, "R3");
    send_byte(8'h02, 1'b1, "R5");
    send_byte(8'h11, 1'b1, "R5");
    send_byte(8'h22, 1'b1, "R5");
    send_byte(8'h33, 1'b1, "R5");
    bus_stop();
    model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
    check_regs("R5");

    // R2: repeated start in the middle of the address byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(8'h9A, 1'b1, "R2");
    send_byte(8'h05, 1'b1, "R2");
    send_byte(8'h55, 1'b1, "R2");
    // R2: stop after three bits of a data byte, nothing stored at 6
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    model[5] = 8'h55;
    check_regs("R2");

    // R4: wrong strap bit and a foreign address are ignored
    bus_start();
    send_byte(8'h98, 1'b0, "R4");
    send_byte(8'h07, 1'b0, "R4");
    send_byte(8'h77, 1'b0, "R4");
    bus_stop();
    bus_start();
    send_byte(8'h40, 1'b0, "R4");
    send_byte(8'h01, 1'b0, "R4");
    bus_stop();
    check_regs("R4");

    // R3: strap low moves the device to 1001100
    strap = 1'b0;
    wt(4);
    bus_start();
    send_byte(8'h98, 1'b1, "R3");
    send_byte(8'h07, 1'b1, "R3");
    send_byte(8'h77, 1'b1, "R3");
    bus_stop();
    bus_start();
    send_byte(8'h9A, 1'b0, "R3");
    bus_stop();
    strap = 1'b1;
    wt(4);
    model[7] = 8'h77;
    check_regs("R3");

    // R6: write saturation at 0x0F
    bus_start();
    send_byte(8'h9A, 1'b1, "R6");
    send_byte(8'h0E, 1'b1, "R6");
    send_byte(8'hA1, 1'b1, "R6");
    send_byte(8'hA2, 1'b1, "R6");
    send_byte(8'hA3, 1'b1, "R6");
    send_byte(8'hA4, 1'b1, "R6");
    bus_stop();
    model[14] = 8'hA1; model[15] = 8'hA4;
    check_regs("R6");

    // R7: base pointers out of range
    bus_start();
    send_byte(8'h9A, 1'b1, "R7");
    send_byte(8'h10, 1'b0, "R7");
    send_byte(8'h5A, 1'b0, "R7");
    bus_stop();
    bus_start();
    send_byte(8'h9A, 1'b1, "R7");
    send_byte(8'hFF, 1'b0, "R7");
    bus_stop();
    check_regs("R7");

    // R8: set base 2, repeated start, read three bytes
    bus_start();
    send_byte(8'h9A, 1'b1, "R8");
    send_byte(8'h02, 1'b1, "R8");
    bus_start();
    send_byte(8'h9B, 1'b1, "R8");
    recv_byte(1'b1, model[2], "R8");
    recv_byte(1'b1, model[3], "R8");
    recv_byte(1'b0, model[4], "R8");
    // R9: after the master refuses, the line stays released
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      check_eq("R9", b, 1);
    end
    bus_stop();

    // R8: a new read resumes after the last byte sent
    bus_start();
    send_byte(8'h9B, 1'b1, "R8");
    recv_byte(1'b0, model[5], "R8");
    bus_stop();

    // R10: read saturation at 0x0F
    bus_start();
    send_byte(8'h9A, 1'b1, "R10");
    send_byte(8'h0F, 1'b1, "R10");
    bus_start();
    send_byte(8'h9B, 1'b1, "R10");
    recv_byte(1'b1, model[15], "R10");
    recv_byte(1'b1, model[15], "R10");
    recv_byte(1'b0, model[15], "R10");
    bus_stop();

    // R11: local read of register 9 on the edge the bus write commits it
    bus_start();
    send_byte(8'h9A, 1'b1, "R11");
    send_byte(8'h09, 1'b1, "R11");
    for (int i = 7; i >= 1; i--) put_bit(i[0] ? 1'b1 : 1'b0);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; mon_hi = 1'b1; wt(2 * Q);
    mon_hi = 1'b0; loc_addr = 4'd9; scl_m = 1'b0;
    wt(4);
    check_eq("R11", loc_data, 8'h00);
    wt(1);
    check_eq("R11", loc_data, 8'hAB);
    wt(Q - 5);
    get_bit(b);
    check_eq("R11", !b, 1);
    bus_stop();
    model[9] = 8'hAB;
    check_regs("R11");

    report();
  end

endmodule